// File: doc/BRIEF.md
# Motor Line Turnaround Sequencer

This block sequences a single shared motor signal line that carries command frames out and, in bidirectional operation, telemetry replies back. When the frame encoder reports that a frame has left the pin, the sequencer decides what the line does next. In bidirectional mode it turns the line around to input and opens a timed capture window for the reply. In one-way motor mode it only enforces a quiet gap. In LED-chain mode it enforces a fixed latch gap. A `ready` output tells the encoder when it may start the next frame.

In a group of four channels only one reply can be captured per frame. The sequencer keeps a selected channel index. At the end of each capture window it moves that index round-robin to the next channel that is both enabled and able to capture. All waits are counted in microseconds from a prescaler derived from the system clock frequency, and every wait starts at the transmit-done strobe.

The frame duration is sampled once, at the accepted transmit-done. The reply itself is not decoded here. The bit-level edge sampler and the decoder sit downstream and are gated by `capture_en`.

Top module: `line_turnaround_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `ready` is 1, `line_dir_in` is 0 (line drives out), and `capture_en` and `rx_done` are 0. `sel_ch` equals the lowest index whose `ch_enable` and `ch_capture_ok` bits are both 1, or 0 when no index qualifies.
- R2: With `mode` = 2'b00 (bidirectional), a `tx_done` sampled while `ready` is 1 sets `line_dir_in` and `capture_en` to 1 from the next cycle. `capture_en` stays 1 for exactly (frame_us + 40) × TPU cycles, where TPU = CLK_HZ / 1e6.
- R3: In bidirectional mode the cycle after the window closes carries a single-cycle `rx_done` pulse, with `line_dir_in` still 1. The line then returns to output and `ready` rises again, so `ready` is 0 for (frame_us + 40) × TPU + 1 cycles in total.
- R4: With `mode` = 2'b01 (one-way motor) or 2'b11 (treated the same way), `ready` is 0 for (frame_us + 70) × TPU cycles after the accepted `tx_done`. `capture_en`, `line_dir_in` and `rx_done` stay 0 throughout.
- R5: With `mode` = 2'b10 (LED chain), `ready` is 0 for 50 × TPU cycles whatever the value of `frame_us`. `capture_en`, `line_dir_in` and `rx_done` stay 0.
- R6: A `tx_done` that arrives while `ready` is 0, including during an open capture window, is ignored: it leaves the window length and the hold-off length unchanged.
- R7: `frame_us` is sampled only at the accepted `tx_done`. Changing it later in the same transaction has no effect on that transaction's timing.
- R8: When a bidirectional capture window closes, `sel_ch` moves to the first index in the order sel+1, sel+2, sel+3 (modulo 4) whose enable and capture bits are both 1. If none qualifies, `sel_ch` keeps its value.
- R9: `sel_ch` changes at no other time. In particular, transactions in one-way and LED-chain modes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done | input | 1 | Single-cycle strobe: the command frame has left the pin |
| ch_enable | input | N_CH | Per-channel enable mask |
| ch_capture_ok | input | N_CH | Per-channel capture-available mask |
| mode | input | 2 | 00 bidirectional, 01 one-way motor, 10 LED chain, 11 as 01 |
| frame_us | input | FRAME_W | Frame duration in microseconds |
| line_dir_in | output | 1 | 1 = line released to input, 0 = line driven |
| capture_en | output | 1 | Edge capture window open |
| sel_ch | output | SEL_W | Channel whose reply is captured |
| rx_done | output | 1 | Single-cycle pulse after the capture window closes |
| ready | output | 1 | Next frame may be started |

## Verification
The assertions assume that `tx_done` is a strobe and that the two channel masks are held steady through a transaction, because the round-robin step reads them at the moment the window closes. The stimulus changes the masks only while reset is held, and it raises `tx_done` as a one-cycle pulse. Deliberately mistimed pulses land only where R6 says they are ignored. Because of this, every change of `sel_ch` is tied to an `rx_done` pulse, and every opening of the window is tied to an accepted strobe.

// File: rtl/turnaround_pkg.sv
package turnaround_pkg;
  typedef enum logic [1:0] {
    MODE_BIDIR  = 2'b00,
    MODE_ONEWAY = 2'b01,
    MODE_LED    = 2'b10,
    MODE_ALT    = 2'b11
  } line_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RECV      = 2'd1,
    ST_RECV_DONE = 2'd2,
    ST_HOLD      = 2'd3
  } seq_state_e;

  localparam int unsigned REPLY_LATENCY_US = 30;
  localparam int unsigned REPLY_MARGIN_US  = 10;
  localparam int unsigned MOTOR_GAP_US     = 40;
  localparam int unsigned LED_GAP_US       = 50;
endpackage

// File: rtl/ta_us_timer.sv
module ta_us_timer #(
  parameter int unsigned TPU   = 100,
  parameter int unsigned LIM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  localparam int unsigned PW = (TPU > 1) ? $clog2(TPU) : 1;
  localparam logic [PW-1:0] PRESC_TOP = PW'(TPU - 1);

  logic [PW-1:0]    presc_q;
  logic [LIM_W-1:0] us_q;
  logic             us_tick;

  assign us_tick = (presc_q == PRESC_TOP);
  assign expire  = run && us_tick && (us_q == limit - LIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      presc_q <= '0;
      us_q    <= '0;
    end else if (run) begin
      if (us_tick) begin
        presc_q <= '0;
        us_q    <= us_q + LIM_W'(1);
      end else begin
        presc_q <= presc_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/ta_chan_rotator.sv
module ta_chan_rotator #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  qual,
  input  logic             advance,
  output logic [SEL_W-1:0] sel
);
  function automatic logic [SEL_W-1:0] lowest_qual(input logic [N_CH-1:0] q);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (q[i]) r = SEL_W'(i);
    end
    return r;
  endfunction

  function automatic logic [SEL_W-1:0] next_qual(input logic [SEL_W-1:0] cur,
                                                 input logic [N_CH-1:0]  q);
    logic [SEL_W-1:0] r;
    int unsigned      idx;
    r = cur;
    for (int k = N_CH - 1; k >= 1; k--) begin
      idx = (int'(cur) + k) % N_CH;
      if (q[idx]) r = SEL_W'(idx);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       sel <= lowest_qual(qual);
    else if (advance) sel <= next_qual(sel, qual);
  end
endmodule

// File: rtl/line_turnaround_seq.sv
module line_turnaround_seq
  import turnaround_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned SEL_W   = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_done,
  input  logic [N_CH-1:0]    ch_enable,
  input  logic [N_CH-1:0]    ch_capture_ok,
  input  logic [1:0]         mode,
  input  logic [FRAME_W-1:0] frame_us,
  output logic               line_dir_in,
  output logic               capture_en,
  output logic [SEL_W-1:0]   sel_ch,
  output logic               rx_done,
  output logic               ready
);
  localparam int unsigned TPU   = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned LIM_W = FRAME_W + 2;

  function automatic logic [LIM_W-1:0] wait_limit(input logic [1:0] m,
                                                  input logic [FRAME_W-1:0] f);
    logic [LIM_W-1:0] fe;
    fe = LIM_W'(f);
    case (line_mode_e'(m))
      MODE_BIDIR: return fe + LIM_W'(REPLY_LATENCY_US + REPLY_MARGIN_US);
      MODE_LED:   return LIM_W'(LED_GAP_US);
      default:    return fe + LIM_W'(REPLY_LATENCY_US + MOTOR_GAP_US);
    endcase
  endfunction

  seq_state_e       state_q;
  logic [LIM_W-1:0] limit_q;
  logic             accept;
  logic             timer_run;
  logic             expire;
  logic             win_end;
  logic             hold_end;

  assign accept    = tx_done && (state_q == ST_IDLE);
  assign timer_run = (state_q == ST_RECV) || (state_q == ST_HOLD);
  assign win_end   = expire && (state_q == ST_RECV);
  assign hold_end  = expire && (state_q == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      limit_q <= '0;
    end else begin
      if (accept) limit_q <= wait_limit(mode, frame_us);
      case (state_q)
        ST_IDLE:      if (accept) state_q <= (line_mode_e'(mode) == MODE_BIDIR) ? ST_RECV : ST_HOLD;
        ST_RECV:      if (win_end) state_q <= ST_RECV_DONE;
        ST_RECV_DONE: state_q <= ST_IDLE;
        ST_HOLD:      if (hold_end) state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  ta_us_timer #(.TPU(TPU), .LIM_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (timer_run),
    .limit  (limit_q),
    .expire (expire)
  );

  ta_chan_rotator #(.N_CH(N_CH), .SEL_W(SEL_W)) u_rot (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual    (ch_enable & ch_capture_ok),
    .advance (win_end),
    .sel     (sel_ch)
  );

  assign capture_en  = (state_q == ST_RECV);
  assign line_dir_in = (state_q == ST_RECV) || (state_q == ST_RECV_DONE);
  assign rx_done     = (state_q == ST_RECV_DONE);
  assign ready       = (state_q == ST_IDLE);
endmodule

// File: rtl/line_turnaround_seq_chk.sv
module line_turnaround_seq_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_done,
  input logic             line_dir_in,
  input logic             capture_en,
  input logic [SEL_W-1:0] sel_ch,
  input logic             rx_done,
  input logic             ready
);
  AST_CAPTURE_INPUT: assert property (@(posedge clk) disable iff (!rst_n) capture_en |-> line_dir_in); // R2
  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n) $rose(capture_en) |-> ($past(tx_done) && $past(ready))); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (!capture_en && !line_dir_in && !rx_done)); // R3
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> (!rx_done && ready)); // R3
  AST_RX_FOLLOWS_WIN: assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> $past(capture_en)); // R3
  AST_SPUR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (capture_en && tx_done) |=> (capture_en || rx_done)); // R6
  AST_SEL_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sel_ch) |-> rx_done); // R9
endmodule

bind line_turnaround_seq line_turnaround_seq_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/line_turnaround_seq_tb.sv
`timescale 1ns/1ps
module line_turnaround_seq_tb;
  localparam int TPU = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_done = 1'b0;
  logic [3:0] ch_enable = 4'b1010;
  logic [3:0] ch_capture_ok = 4'b1110;
  logic [1:0] mode = 2'b00;
  logic [7:0] frame_us = 8'd0;
  logic       line_dir_in, capture_en, rx_done, ready;
  logic [1:0] sel_ch;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  line_turnaround_seq #(.CLK_HZ(TPU * 1_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .ch_enable(ch_enable),
    .ch_capture_ok(ch_capture_ok), .mode(mode), .frame_us(frame_us),
    .line_dir_in(line_dir_in), .capture_en(capture_en), .sel_ch(sel_ch),
    .rx_done(rx_done), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int first_q(input int q);
    for (int i = 0; i < 4; i++) if (q[i]) return i;
    return 0;
  endfunction

  function automatic int step_q(input int cur, input int q);
    for (int k = 1; k < 4; k++) if (q[(cur + k) % 4]) return (cur + k) % 4;
    return cur;
  endfunction

  task automatic do_reset(input logic [3:0] en, input logic [3:0] cap);
    @(negedge clk);
    rst_n = 1'b0; ch_enable = en; ch_capture_ok = cap;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one transaction; optional spurious strobe and frame change inside it
  task automatic txn(input int m, input int f, input bit disturb,
                     output int nr, output int ncap, output int ndir, output int nrx);
    nr = 0; ncap = 0; ndir = 0; nrx = 0;
    @(negedge clk);
    mode = 2'(m); frame_us = 8'(f); tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    for (int i = 0; i < 2000 && !ready; i++) begin
      nr++;
      if (capture_en) ncap++;
      if (line_dir_in) ndir++;
      if (rx_done) nrx++;
      if (disturb && i == 3) frame_us = 8'(f + 100);
      tx_done = (disturb && i == 5);
      @(negedge clk);
    end
    tx_done = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nr, nc, nd, nx, exp_sel, q, n;
    int fr[4] = '{0, 3, 17, 255};
    do_reset(4'b1010, 4'b1110);
    #1;
    check("R1 ready", int'(ready), 1);
    check("R1 dir", int'(line_dir_in), 0);
    check("R1 cap", int'(capture_en), 0);
    check("R1 rx", int'(rx_done), 0);
    check("R1 sel", int'(sel_ch), 1);

    // timing sweep over modes and frame lengths
    for (int m = 0; m < 4; m++) begin
      for (int fi = 0; fi < 4; fi++) begin
        exp_sel = int'(sel_ch);
        txn(m, fr[fi], 1'b0, nr, nc, nd, nx);
        if (m == 0) begin
          n = (fr[fi] + 40) * TPU;
          check("R2 window", nc, n);
          check("R3 ready low", nr, n + 1);
          check("R3 dir", nd, n + 1);
          check("R3 rx pulse", nx, 1);
          check("R8 sel", int'(sel_ch), step_q(exp_sel, 4'b1010));
        end else begin
          n = (m == 2) ? 50 * TPU : (fr[fi] + 70) * TPU;
          check(m == 2 ? "R5 holdoff" : "R4 holdoff", nr, n);
          check("R4 R5 cap", nc, 0);
          check("R4 R5 dir", nd, 0);
          check("R4 R5 rx", nx, 0);
          check("R9 sel", int'(sel_ch), exp_sel);
        end
      end
    end

    // spurious strobe and late frame change (R6, R7)
    txn(0, 10, 1'b1, nr, nc, nd, nx);
    check("R6 R7 window", nc, 50 * TPU);
    check("R6 R7 ready low", nr, 50 * TPU + 1);
    txn(1, 10, 1'b1, nr, nc, nd, nx);
    check("R6 R7 holdoff", nr, 80 * TPU);
    check("R6 cap", nc, 0);

    // exhaustive mask sweep: reset choice and rotation
    for (int e = 0; e < 16; e++) begin
      for (int c = 0; c < 16; c++) begin
        do_reset(4'(e), 4'(c));
        q = e & c;
        exp_sel = first_q(q);
        #1;
        check("R1 first sel", int'(sel_ch), exp_sel);
        for (int t = 0; t < 3; t++) begin
          txn(0, 0, 1'b0, nr, nc, nd, nx);
          exp_sel = step_q(exp_sel, q);
          check("R8 rotate", int'(sel_ch), exp_sel);
        end
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule